// File: doc/BRIEF.md
# Little-Endian Multi-Width Data Memory

This block is a byte-organised data store that serves 8-bit, 16-bit and 32-bit loads and stores through one byte address. Multi-byte values are spread over consecutive byte locations with the least significant byte at the addressed location and higher-order bytes at rising addresses. Reads are registered and return one cycle after the request, zero-extended to 32 bits.

The address space is split by a fixed map. The lowest locations form a region that loads may read but stores may not change. Near the top of memory sits a small window of writable IO: byte stores that land there are sent out on a strobe port with the byte and its offset in the window, instead of being written into the array. Any request that breaks the map gets a one-cycle error pulse and changes no state. Requests that break the map are a reserved size code, a span running past the last location, a store into the read-only region, or a multi-byte store touching the IO window.

Top module: `lemem_top`

## Requirements
- R1: Size code 0 is a byte access to the single location at the address; a byte load returns that location in bits 7:0 with bits 31:8 zero.
- R2: Size code 2 is a long access over four consecutive locations; a store places write-data bits 7:0 at the address and each higher byte at the next location up, and a long load reassembles them the same way.
- R3: Size code 1 is a short access over two consecutive locations in the same little-endian order; a short load returns bits 31:16 as zero.
- R4: After a store, a load of any overlapping span returns the newly written bytes, and locations outside the store's span keep their values.
- R5: An accepted load raises the read-valid output with its data exactly one cycle after the request; stores and rejected requests never raise it.
- R6: Locations below RO_BYTES (64) are readable and hold after reset the value (29*i + 7) mod 256 at location i; a store whose start address is below RO_BYTES is rejected with an error and changes nothing.
- R7: A load or store whose last byte lies at or above MEM_BYTES (512) is rejected with an error, produces no read data and changes nothing.
- R8: A byte store to an address inside the IO window [IO_BASE, IO_BASE+IO_BYTES) (480 to 495) raises the IO strobe one cycle later with the offset address minus IO_BASE and write-data bits 7:0; memory is left unchanged.
- R9: A short or long store whose span overlaps the IO window is rejected with an error, raises no IO strobe and changes nothing.
- R10: Size code 3 is reserved; any request with it is rejected with an error and changes nothing.
- R11: The error output pulses high for exactly the one cycle after each rejected request and is low otherwise; after reset all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present this cycle |
| reqWrite | input | 1 | 1 = store, 0 = load |
| reqSize | input | 2 | 0 byte, 1 short, 2 long, 3 reserved |
| reqAddr | input | ADDR_W (12) | Byte address of lowest location |
| reqWdata | input | 32 | Store data, least significant byte first in memory |
| rdValid | output | 1 | Load data valid |
| rdData | output | 32 | Zero-extended load data |
| accErr | output | 1 | One-cycle rejection pulse |
| ioStrobe | output | 1 | IO window byte write |
| ioOffset | output | IO_OFF_W (4) | Offset within the IO window |
| ioData | output | 8 | IO byte value |

## Verification
The bench aims at spans that straddle boundaries: a long access whose last byte sits exactly on the final location versus one past it, a short store that reaches into the IO window from below, and overlapping stores of different widths. A design with swapped lanes would return byte-reversed words, one that checked only the start address would write beyond memory or into the IO window, and one that forgot zero extension would leak stale high bytes into short and byte loads. Random mixes of all sizes and addresses just past the bound are compared against a bench byte model to catch writes that a rejected request should have suppressed.

// File: rtl/lemem_pkg.sv
package lemem_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE  = 2'd0,
    SZ_SHORT = 2'd1,
    SZ_LONG  = 2'd2,
    SZ_RSVD  = 2'd3
  } accSize_e;

  // control-to-datapath strobes
  typedef struct packed {
    logic       memWr;
    logic       memRd;
    logic       ioWr;
    logic [3:0] laneEn;
  } memStrobe_t;

  // reset contents of every location
  function automatic logic [7:0] initByte(input int unsigned idx);
    return 8'((idx * 29 + 7) & 255);
  endfunction

endpackage

// File: rtl/lemem_ctrl.sv
module lemem_ctrl
  import lemem_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int MEM_BYTES = 512,
  parameter int RO_BYTES  = 64,
  parameter int IO_BASE   = 480,
  parameter int IO_BYTES  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [1:0]        reqSize,
  input  logic [ADDR_W-1:0] reqAddr,
  output memStrobe_t        strobe,
  output logic              accErr
);

  localparam int SPAN_W = ADDR_W + 1;

  logic [2:0]        spanBytes;
  logic [SPAN_W-1:0] firstAddr;
  logic [SPAN_W-1:0] lastAddr;
  logic              badSize, outRange, roHit, ioHit, isByte, reject;

  always_comb begin
    unique case (accSize_e'(reqSize))
      SZ_BYTE:  spanBytes = 3'd1;
      SZ_SHORT: spanBytes = 3'd2;
      SZ_LONG:  spanBytes = 3'd4;
      default:  spanBytes = 3'd1;
    endcase
    firstAddr = {1'b0, reqAddr};
    lastAddr  = firstAddr + SPAN_W'(spanBytes) - SPAN_W'(1);
    badSize   = (accSize_e'(reqSize) == SZ_RSVD);
    isByte    = (accSize_e'(reqSize) == SZ_BYTE);
    outRange  = lastAddr > SPAN_W'(MEM_BYTES - 1);
    roHit     = firstAddr < SPAN_W'(RO_BYTES);
    ioHit     = (firstAddr < SPAN_W'(IO_BASE + IO_BYTES)) &&
                (lastAddr >= SPAN_W'(IO_BASE));
    reject    = reqValid &&
                (badSize || outRange ||
                 (reqWrite && (roHit || (ioHit && !isByte))));

    strobe.memRd = reqValid && !reqWrite && !reject;
    strobe.ioWr  = reqValid &&  reqWrite && !reject &&  ioHit;
    strobe.memWr = reqValid &&  reqWrite && !reject && !ioHit;
    for (int l = 0; l < 4; l++) begin
      strobe.laneEn[l] = (l < int'(spanBytes));
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) accErr <= 1'b0;
    else       accErr <= reject;
  end

endmodule

// File: rtl/lemem_dpath.sv
module lemem_dpath
  import lemem_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int MEM_BYTES = 512,
  parameter int IO_BASE   = 480,
  parameter int IO_BYTES  = 16,
  localparam int IDX_W    = $clog2(MEM_BYTES),
  localparam int IO_OFF_W = $clog2(IO_BYTES)
) (
  input  logic                clk,
  input  logic                rstN,
  input  memStrobe_t          strobe,
  input  logic [ADDR_W-1:0]   reqAddr,
  input  logic [31:0]         reqWdata,
  output logic                rdValid,
  output logic [31:0]         rdData,
  output logic                ioStrobe,
  output logic [IO_OFF_W-1:0] ioOffset,
  output logic [7:0]          ioData
);

  logic [7:0]       memArr [MEM_BYTES];
  logic [IDX_W-1:0] laneAddr [4];
  logic [7:0]       laneRd [4];
  logic [31:0]      rdAsm;

  // one byte lane per 8 bits of the word, lane 0 at the lowest address
  for (genvar l = 0; l < 4; l++) begin : g_lane
    assign laneAddr[l] = IDX_W'(reqAddr) + IDX_W'(l);
    assign laneRd[l]   = strobe.laneEn[l] ? memArr[laneAddr[l]] : 8'h00;
    assign rdAsm[8*l +: 8] = laneRd[l];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < MEM_BYTES; i++) memArr[i] <= initByte(i);
    end else if (strobe.memWr) begin
      for (int l = 0; l < 4; l++) begin
        if (strobe.laneEn[l]) memArr[laneAddr[l]] <= reqWdata[8*l +: 8];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdValid  <= 1'b0;
      rdData   <= '0;
      ioStrobe <= 1'b0;
      ioOffset <= '0;
      ioData   <= '0;
    end else begin
      rdValid  <= strobe.memRd;
      ioStrobe <= strobe.ioWr;
      if (strobe.memRd) rdData <= rdAsm;
      if (strobe.ioWr) begin
        ioOffset <= IO_OFF_W'(reqAddr - ADDR_W'(IO_BASE));
        ioData   <= reqWdata[7:0];
      end
    end
  end

endmodule

// File: rtl/lemem_top.sv
module lemem_top
  import lemem_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int MEM_BYTES = 512,
  parameter int RO_BYTES  = 64,
  parameter int IO_BASE   = 480,
  parameter int IO_BYTES  = 16,
  localparam int IO_OFF_W = $clog2(IO_BYTES)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                reqValid,
  input  logic                reqWrite,
  input  logic [1:0]          reqSize,
  input  logic [ADDR_W-1:0]   reqAddr,
  input  logic [31:0]         reqWdata,
  output logic                rdValid,
  output logic [31:0]         rdData,
  output logic                accErr,
  output logic                ioStrobe,
  output logic [IO_OFF_W-1:0] ioOffset,
  output logic [7:0]          ioData
);

  memStrobe_t strobe;

  lemem_ctrl #(
    .ADDR_W(ADDR_W), .MEM_BYTES(MEM_BYTES), .RO_BYTES(RO_BYTES),
    .IO_BASE(IO_BASE), .IO_BYTES(IO_BYTES)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqSize(reqSize), .reqAddr(reqAddr), .strobe(strobe), .accErr(accErr)
  );

  lemem_dpath #(
    .ADDR_W(ADDR_W), .MEM_BYTES(MEM_BYTES),
    .IO_BASE(IO_BASE), .IO_BYTES(IO_BYTES)
  ) u_dpath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .reqAddr(reqAddr),
    .reqWdata(reqWdata), .rdValid(rdValid), .rdData(rdData),
    .ioStrobe(ioStrobe), .ioOffset(ioOffset), .ioData(ioData)
  );

endmodule

// File: rtl/lemem_chk.sv
module lemem_chk #(
  parameter int ADDR_W    = 12,
  parameter int MEM_BYTES = 512,
  parameter int RO_BYTES  = 64,
  parameter int IO_BASE   = 480,
  parameter int IO_BYTES  = 16,
  localparam int IO_OFF_W = $clog2(IO_BYTES)
) (
  input logic                clk,
  input logic                rstN,
  input logic                reqValid,
  input logic                reqWrite,
  input logic [1:0]          reqSize,
  input logic [ADDR_W-1:0]   reqAddr,
  input logic                rdValid,
  input logic [31:0]         rdData,
  input logic                accErr,
  input logic                ioStrobe,
  input logic [IO_OFF_W-1:0] ioOffset
);

  // R5
  rd_after_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |-> $past(reqValid && !reqWrite));

  // R1
  byte_zext_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !reqWrite && reqSize == 2'd0) |=> (!rdValid || rdData[31:8] == 24'h0));

  // R3
  short_zext_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !reqWrite && reqSize == 2'd1) |=> (!rdValid || rdData[31:16] == 16'h0));

  // R6
  ro_store_err_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqWrite && reqAddr < ADDR_W'(RO_BYTES)) |=> (accErr && !ioStrobe));

  // R7
  out_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqAddr >= ADDR_W'(MEM_BYTES)) |=> (accErr && !rdValid));

  // R10
  rsvd_size_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqSize == 2'd3) |=> (accErr && !rdValid && !ioStrobe));

  // R8
  io_from_byte_store_chk: assert property (@(posedge clk) disable iff (!rstN)
    ioStrobe |-> $past(reqValid && reqWrite && reqSize == 2'd0));

  // R11
  err_needs_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    accErr |-> $past(reqValid));

  // R11
  err_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    accErr |-> (!rdValid && !ioStrobe));

endmodule

bind lemem_top lemem_chk #(
  .ADDR_W(ADDR_W), .MEM_BYTES(MEM_BYTES), .RO_BYTES(RO_BYTES),
  .IO_BASE(IO_BASE), .IO_BYTES(IO_BYTES)
) u_chk (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
  .reqSize(reqSize), .reqAddr(reqAddr), .rdValid(rdValid), .rdData(rdData),
  .accErr(accErr), .ioStrobe(ioStrobe), .ioOffset(ioOffset)
);

// File: tb/lemem_top_bench.sv
module lemem_top_bench;

  localparam int ADDR_W    = 12;
  localparam int MEM_BYTES = 512;
  localparam int RO_BYTES  = 64;
  localparam int IO_BASE   = 480;
  localparam int IO_BYTES  = 16;
  localparam int IO_OFF_W  = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0;
  logic reqWrite = 1'b0;
  logic [1:0] reqSize = 2'd0;
  logic [ADDR_W-1:0] reqAddr = '0;
  logic [31:0] reqWdata = '0;
  logic rdValid;
  logic [31:0] rdData;
  logic accErr;
  logic ioStrobe;
  logic [IO_OFF_W-1:0] ioOffset;
  logic [7:0] ioData;

  int nChecks = 0;
  int nFail = 0;
  logic [7:0] refMem [MEM_BYTES];

  always #2 clk = ~clk;

  lemem_top u_lemem_top (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqSize(reqSize), .reqAddr(reqAddr), .reqWdata(reqWdata),
    .rdValid(rdValid), .rdData(rdData), .accErr(accErr),
    .ioStrobe(ioStrobe), .ioOffset(ioOffset), .ioData(ioData)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic int spanOf(input logic [1:0] sz);
    return (sz == 2'd1) ? 2 : (sz == 2'd2) ? 4 : 1;
  endfunction

  // one request, checked at the next falling edge; returns the observed data
  task automatic doOp(input bit wr, input logic [1:0] sz, input int addr,
                      input logic [31:0] wd, output logic [31:0] got);
    int  span = spanOf(sz);
    int  last = addr + span - 1;
    bit  ioHit = (addr < IO_BASE + IO_BYTES) && (last >= IO_BASE);
    bit  eSize = (sz == 2'd3);
    bit  eRange = (last >= MEM_BYTES);
    bit  eRo = wr && (addr < RO_BYTES);
    bit  eIo = wr && ioHit && (sz != 2'd0);
    bit  expErr = eSize || eRange || eRo || eIo;
    bit  expRd = !wr && !expErr;
    bit  expIo = wr && !expErr && ioHit;
    logic [31:0] expData = '0;
    string eTag, dTag;
    eTag = eSize ? "R10" : eRange ? "R7" : eRo ? "R6" : eIo ? "R9" : "R11";
    dTag = (addr < RO_BYTES) ? "R6" : (sz == 2'd0) ? "R1" : (sz == 2'd1) ? "R3" : "R2";
    if (expRd)
      for (int l = 0; l < span; l++) expData[8*l +: 8] = refMem[addr + l];
    reqValid = 1'b1; reqWrite = wr; reqSize = sz;
    reqAddr = ADDR_W'(addr); reqWdata = wd;
    if (wr && !expErr && !ioHit)
      for (int l = 0; l < span; l++) refMem[addr + l] = wd[8*l +: 8];
    @(negedge clk);
    reqValid = 1'b0;
    got = rdData;
    chk(accErr == expErr, eTag, 32'(accErr), 32'(expErr));
    chk(rdValid == expRd, "R5", 32'(rdValid), 32'(expRd));
    if (expRd) chk(rdData == expData, dTag, rdData, expData);
    chk(ioStrobe == expIo, "R8", 32'(ioStrobe), 32'(expIo));
    if (expIo) begin
      chk(ioOffset == IO_OFF_W'(addr - IO_BASE), "R8", 32'(ioOffset), 32'(addr - IO_BASE));
      chk(ioData == wd[7:0], "R8", 32'(ioData), 32'(wd[7:0]));
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nChecks++; nFail++;
    $display("FAIL R11 watchdog expired actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  end

  initial begin
    logic [31:0] got;
    void'($urandom(32'd20240611));
    for (int i = 0; i < MEM_BYTES; i++) refMem[i] = 8'((i * 29 + 7) & 255);
    repeat (3) @(negedge clk);
    // R11: reset state
    chk(!rdValid && !accErr && !ioStrobe && rdData == 0, "R11",
        {rdValid, accErr, ioStrobe, rdData[28:0]}, 32'h0);
    rstN = 1'b1;
    @(negedge clk);

    // R2: long store lane order, then byte loads of each location
    doOp(1'b1, 2'd2, 100, 32'hA1B2C3D4, got);
    doOp(1'b0, 2'd0, 100, 0, got); chk(got == 32'hD4, "R2", got, 32'hD4);
    doOp(1'b0, 2'd0, 103, 0, got); chk(got == 32'hA1, "R2", got, 32'hA1);
    doOp(1'b0, 2'd2, 100, 0, got); chk(got == 32'hA1B2C3D4, "R2", got, 32'hA1B2C3D4);
    // R3: short store and zero extension
    doOp(1'b1, 2'd1, 200, 32'hFFFF9A5E, got);
    doOp(1'b0, 2'd1, 200, 0, got); chk(got == 32'h9A5E, "R3", got, 32'h9A5E);
    doOp(1'b0, 2'd0, 201, 0, got); chk(got == 32'h9A, "R1", got, 32'h9A);
    // R4: overlapping widths, neighbours untouched
    doOp(1'b1, 2'd2, 300, 32'h11223344, got);
    doOp(1'b1, 2'd1, 301, 32'h0000BEEF, got);
    doOp(1'b0, 2'd2, 300, 0, got); chk(got == 32'h11BEEF44, "R4", got, 32'h11BEEF44);
    doOp(1'b0, 2'd0, 299, 0, got);
    chk(got == 32'((299 * 29 + 7) & 255), "R4", got, 32'((299 * 29 + 7) & 255));
    // R6: read-only contents and rejected store
    doOp(1'b0, 2'd2, 4, 0, got);
    doOp(1'b1, 2'd0, 10, 32'h55, got);
    doOp(1'b0, 2'd0, 10, 0, got); chk(got == 32'((10 * 29 + 7) & 255), "R6", got, 32'((10 * 29 + 7) & 255));
    doOp(1'b1, 2'd2, 62, 32'hDEADBEEF, got);
    doOp(1'b1, 2'd2, 64, 32'hCAFEF00D, got);
    // R7: span at and past the bound
    doOp(1'b0, 2'd2, 508, 0, got);
    doOp(1'b0, 2'd2, 509, 0, got);
    doOp(1'b1, 2'd1, 511, 32'h1234, got);
    doOp(1'b0, 2'd0, 511, 0, got);
    doOp(1'b0, 2'd0, 4000, 0, got);
    // R8: IO window byte store leaves memory alone
    doOp(1'b1, 2'd0, 485, 32'h0000007E, got);
    doOp(1'b0, 2'd0, 485, 0, got);
    chk(got == 32'((485 * 29 + 7) & 255), "R8", got, 32'((485 * 29 + 7) & 255));
    doOp(1'b1, 2'd0, 495, 32'h000000C3, got);
    // R9: multi-byte stores touching the window
    doOp(1'b1, 2'd1, 479, 32'hABCD, got);
    doOp(1'b1, 2'd2, 494, 32'h01020304, got);
    doOp(1'b0, 2'd0, 479, 0, got);
    // R10: reserved size
    doOp(1'b0, 2'd3, 150, 0, got);
    doOp(1'b1, 2'd3, 150, 32'hFFFFFFFF, got);
    // R11: error followed by a clean request
    doOp(1'b0, 2'd0, 150, 0, got);

    // random mix
    for (int n = 0; n < 4000; n++) begin
      int a = $urandom_range(0, MEM_BYTES + 7);
      logic [1:0] s = 2'($urandom_range(0, 3));
      bit w = ($urandom_range(0, 1) == 1);
      if ($urandom_range(0, 7) == 0) a = IO_BASE - 2 + $urandom_range(0, IO_BYTES + 3);
      if ($urandom_range(0, 9) == 0) s = 2'd2 - 2'($urandom_range(0, 1));
      doOp(w, s, a, $urandom, got);
    end

    $display("[TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  end

endmodule